// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator with Fault Injection

The block turns one PWM logic input into two gate-enable outputs for a half-bridge. One output drives the high-side switch and one drives the low-side switch. When the input is steady at 1 the high side is on, and when it is steady at 0 the low side is on.

Every input edge starts a break-before-make sequence timed in clock cycles. First the conducting side turns off after a propagation delay. Then both outputs stay off for a dead time, and only after that does the other side turn on. Each edge direction has its own delay and its own dead time, so there are four independent settings. If the input reverses while a sequence is still running, that sequence is dropped and the opposite one starts from the present output state.

A fault injector counts cycles from reset. When a programmed activation time is reached, it latches one of eight fault modes until the next reset. Two of the modes pin the input at 0 or at 1 ahead of the sequencer, so dead-time handling still applies. The other six override one output or both outputs after the sequencer.

Top module: `hb_gate_deadtime`

## Requirements
- R1: While `rst` is high, both outputs are 0. On the first clock edge after reset is released, the sequencer enters a both-off dead interval, using the falling-edge dead time if the input is 0 and the rising-edge dead time if it is 1. After that interval, the matching side turns on.
- R2: The sequencer first sees a 0-to-1 input at clock edge E. The low-side output turns off at edge E+1+`rise_prop`.
- R3: After the low side turns off at edge D on a rising sequence, the high side turns on at edge D+1+`rise_dead`. So there is always at least one both-off cycle. With no fault active, the outputs are never both 1.
- R4: The sequencer first sees a 1-to-0 input at edge E. The high-side output turns off at edge E+1+`fall_prop`.
- R5: After the high side turns off at edge D on a falling sequence, the low side turns on at edge D+1+`fall_dead`.
- R6: Suppose the input returns to its old level during the propagation phase. Then the outputs stay in their old steady state. Suppose instead it reverses during the dead phase. Then the opposite dead interval starts at once (the off side is already off), and its length is the dead time for the new edge direction.
- R7: `fault_sel` uses this encoding: 0 none, 1 input held 0, 2 input held 1, 3 high off, 4 high on, 5 low off, 6 low on, 7 both off, 8 both on. Values 9 to 15 act as none. A cycle counter is cleared by reset. The selected mode latches at the first edge where the counter value is at least `fault_at`, which is edge T+1 after release for `fault_at`=T. Once latched, the mode holds until reset, and later changes to `fault_sel` have no effect.
- R8: The input-held faults (modes 1 and 2) replace the PWM input before the sequencer. The resulting change is timed by R2 to R5, starting at the edge after the fault latches.
- R9: The forcing faults (modes 3 to 8) override the named outputs in the same cycle the fault latches. Any output they do not name keeps the sequencer value.
- R10: A delay or dead-time setting of 0 makes that step happen on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM logic input |
| rise_prop | input | 16 | Cycles before the low side turns off on a rising input |
| rise_dead | input | 16 | Dead cycles before the high side turns on |
| fall_prop | input | 16 | Cycles before the high side turns off on a falling input |
| fall_dead | input | 16 | Dead cycles before the low side turns on |
| fault_sel | input | 4 | Fault mode code |
| fault_at | input | 32 | Fault activation cycle count |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
Suppose an input change is applied in the low phase of clock cycle c. The sequencer sees it at edge c+1. The low or high side then drops at edge c+2 plus the propagation delay, and the other side rises one edge plus the dead time after that. A fault with `fault_at`=T acts at edge T+1 after reset release. An input-held fault feeds the sequencer one edge later than that. For each stimulus, the driver pushes the expected output pairs into a queue with the edge number at which each is due, including the last cycle before each step. The monitor samples in the low phase after that numbered edge, and any item whose edge has already passed counts as a failure.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int FLT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ON_HI,
        ST_ON_LO,
        ST_RISE_PROP,
        ST_RISE_DEAD,
        ST_FALL_PROP,
        ST_FALL_DEAD
    } seq_state_e;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE     = 4'd0,
        FLT_IN_LOW   = 4'd1,
        FLT_IN_HIGH  = 4'd2,
        FLT_HS_OFF   = 4'd3,
        FLT_HS_ON    = 4'd4,
        FLT_LS_OFF   = 4'd5,
        FLT_LS_ON    = 4'd6,
        FLT_BOTH_OFF = 4'd7,
        FLT_BOTH_ON  = 4'd8
    } fault_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    function automatic logic fault_code_valid(logic [FLT_W-1:0] code);
        return (code != 4'd0) && (code <= 4'd8);
    endfunction

    // Input seen by the sequencer once input-held faults are applied.
    function automatic logic effective_pwm(fault_e f, logic active, logic pwm);
        if (!active)               return pwm;
        else if (f == FLT_IN_LOW)  return 1'b0;
        else if (f == FLT_IN_HIGH) return 1'b1;
        else                       return pwm;
    endfunction

    // Output override applied after the sequencer.
    function automatic gate_t force_gates(fault_e f, logic active, gate_t g);
        gate_t r;
        r = g;
        if (active) begin
            case (f)
                FLT_HS_OFF:   r.hs = 1'b0;
                FLT_HS_ON:    r.hs = 1'b1;
                FLT_LS_OFF:   r.ls = 1'b0;
                FLT_LS_ON:    r.ls = 1'b1;
                FLT_BOTH_OFF: r = '{hs: 1'b0, ls: 1'b0};
                FLT_BOTH_ON:  r = '{hs: 1'b1, ls: 1'b1};
                default:      r = g;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/hb_fault_arm.sv
module hb_fault_arm
    import hb_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLT_W-1:0]  mode_in,
    input  logic [TIME_W-1:0] act_time,
    output logic              active,
    output fault_e            mode_q
);

    logic [TIME_W-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc    <= '0;
            active <= 1'b0;
            mode_q <= FLT_NONE;
        end else begin
            cyc <= cyc + 1'b1;
            if (!active && fault_code_valid(mode_in) && (cyc >= act_time)) begin
                active <= 1'b1;
                mode_q <= fault_e'(mode_in);
            end
        end
    end

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        active |=> active);

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(mode_q));

endmodule

// File: rtl/hb_sequencer.sv
module hb_sequencer
    import hb_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm,
    input  logic [DLY_W-1:0] tp_rise,
    input  logic [DLY_W-1:0] td_rise,
    input  logic [DLY_W-1:0] tp_fall,
    input  logic [DLY_W-1:0] td_fall,
    output gate_t            gate
);

    seq_state_e       st;
    logic [DLY_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (pwm) begin st <= ST_RISE_DEAD; cnt <= td_rise; end
                    else     begin st <= ST_FALL_DEAD; cnt <= td_fall; end
                end
                ST_ON_LO: begin
                    if (pwm) begin st <= ST_RISE_PROP; cnt <= tp_rise; end
                end
                ST_RISE_PROP: begin
                    if (!pwm)          st <= ST_ON_LO;
                    else if (cnt_zero) begin st <= ST_RISE_DEAD; cnt <= td_rise; end
                    else               cnt <= cnt - 1'b1;
                end
                ST_RISE_DEAD: begin
                    if (!pwm)          begin st <= ST_FALL_DEAD; cnt <= td_fall; end
                    else if (cnt_zero) st <= ST_ON_HI;
                    else               cnt <= cnt - 1'b1;
                end
                ST_ON_HI: begin
                    if (!pwm) begin st <= ST_FALL_PROP; cnt <= tp_fall; end
                end
                ST_FALL_PROP: begin
                    if (pwm)           st <= ST_ON_HI;
                    else if (cnt_zero) begin st <= ST_FALL_DEAD; cnt <= td_fall; end
                    else               cnt <= cnt - 1'b1;
                end
                ST_FALL_DEAD: begin
                    if (pwm)           begin st <= ST_RISE_DEAD; cnt <= td_rise; end
                    else if (cnt_zero) st <= ST_ON_LO;
                    else               cnt <= cnt - 1'b1;
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign gate.hs = (st == ST_ON_HI) || (st == ST_FALL_PROP);
    assign gate.ls = (st == ST_ON_LO) || (st == ST_RISE_PROP);

    // Break before make: a side only turns on after a cycle with the other side off.
    assert_hs_break_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.hs) |-> !$past(gate.ls));

    assert_ls_break_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.ls) |-> !$past(gate.hs));

endmodule

// File: rtl/hb_gate_deadtime.sv
module hb_gate_deadtime
    import hb_pkg::*;
#(
    parameter int DLY_W  = 16,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic [DLY_W-1:0]  rise_prop,
    input  logic [DLY_W-1:0]  rise_dead,
    input  logic [DLY_W-1:0]  fall_prop,
    input  logic [DLY_W-1:0]  fall_dead,
    input  logic [3:0]        fault_sel,
    input  logic [TIME_W-1:0] fault_at,
    output logic              hs_on,
    output logic              ls_on
);

    logic   flt_active;
    fault_e flt_mode;
    logic   pwm_eff;
    gate_t  seq_gate;
    gate_t  out_gate;

    hb_fault_arm #(.TIME_W(TIME_W)) u_fault (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (fault_sel),
        .act_time (fault_at),
        .active   (flt_active),
        .mode_q   (flt_mode)
    );

    assign pwm_eff = effective_pwm(flt_mode, flt_active, pwm_in);

    hb_sequencer #(.DLY_W(DLY_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pwm     (pwm_eff),
        .tp_rise (rise_prop),
        .td_rise (rise_dead),
        .tp_fall (fall_prop),
        .td_fall (fall_dead),
        .gate    (seq_gate)
    );

    assign out_gate = force_gates(flt_mode, flt_active, seq_gate);
    assign hs_on    = out_gate.hs;
    assign ls_on    = out_gate.ls;

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !flt_active |-> !(hs_on && ls_on));

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> (!hs_on && !ls_on));

endmodule

// File: tb/sim_hb_gate_deadtime.sv
module sim_hb_gate_deadtime;

    typedef struct {
        int    at;
        logic  hs;
        logic  ls;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwm_in = 1'b0;
    logic [15:0] rise_prop = '0, rise_dead = '0, fall_prop = '0, fall_dead = '0;
    logic [3:0]  fault_sel = '0;
    logic [31:0] fault_at = '1;
    logic        hs_on, ls_on;

    int   cyc_tb = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    hb_gate_deadtime u0 (
        .clk(clk), .rst(rst), .pwm_in(pwm_in),
        .rise_prop(rise_prop), .rise_dead(rise_dead),
        .fall_prop(fall_prop), .fall_dead(fall_dead),
        .fault_sel(fault_sel), .fault_at(fault_at),
        .hs_on(hs_on), .ls_on(ls_on)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc_tb <= cyc_tb + 1;

    task automatic check(string req, logic ghs, logic gls, logic ehs, logic els);
        checks++;
        if (ghs !== ehs || gls !== els) begin
            errors++;
            $display("FAIL %s cycle %0d actual hs=%0b ls=%0b expected hs=%0b ls=%0b",
                     req, cyc_tb, ghs, gls, ehs, els);
        end
    endtask

    task automatic push(int at, logic hs, logic ls, string req);
        exp_t e;
        e.at = at; e.hs = hs; e.ls = ls; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compares each queued item in the low phase after its due edge.
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc_tb) begin
            e = sb.pop_front();
            if (e.at < cyc_tb) begin
                checks++;
                errors++;
                $display("FAIL %s missed edge %0d actual none expected hs=%0b ls=%0b",
                         e.req, e.at, e.hs, e.ls);
            end else begin
                check(e.req, hs_on, ls_on, e.hs, e.ls);
            end
        end
    end

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(output int c);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", hs_on, ls_on, 1'b0, 1'b0);
        rst = 1'b0;
        c = cyc_tb;
    endtask

    task automatic rise_seq(logic [15:0] tp, logic [15:0] dt, string req);
        int c;
        @(negedge clk);
        rise_prop = tp; rise_dead = dt;
        pwm_in = 1'b1;
        c = cyc_tb;
        push(c + 1 + tp,      1'b0, 1'b1, req);
        push(c + 2 + tp,      1'b0, 1'b0, req);
        push(c + 2 + tp + dt, 1'b0, 1'b0, req);
        push(c + 3 + tp + dt, 1'b1, 1'b0, req);
        drain();
    endtask

    task automatic fall_seq(logic [15:0] tp, logic [15:0] dt, string req);
        int c;
        @(negedge clk);
        fall_prop = tp; fall_dead = dt;
        pwm_in = 1'b0;
        c = cyc_tb;
        push(c + 1 + tp,      1'b1, 1'b0, req);
        push(c + 2 + tp,      1'b0, 1'b0, req);
        push(c + 2 + tp + dt, 1'b0, 1'b0, req);
        push(c + 3 + tp + dt, 1'b0, 1'b1, req);
        drain();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        // R1 / R5: start-up from input 0 with a falling dead time of 3
        fall_dead = 16'd3;
        do_reset(c);
        push(c + 1, 1'b0, 1'b0, "R1");
        push(c + 4, 1'b0, 1'b0, "R1");
        push(c + 5, 1'b0, 1'b1, "R5");
        drain();

        // R2 / R3: rising sequence
        rise_seq(16'd2, 16'd3, "R2_R3");
        // R4 / R5: falling sequence
        fall_seq(16'd4, 16'd1, "R4_R5");
        // R10: zero delays
        rise_seq(16'd0, 16'd0, "R10");
        fall_seq(16'd0, 16'd0, "R10");
        rise_seq(16'd5, 16'd2, "R2_R3");

        // R6: reversal during the falling propagation phase
        @(negedge clk);
        fall_prop = 16'd5; fall_dead = 16'd1;
        pwm_in = 1'b0;
        c = cyc_tb;
        push(c + 3, 1'b1, 1'b0, "R6");
        push(c + 7, 1'b1, 1'b0, "R6");
        push(c + 9, 1'b1, 1'b0, "R6");
        repeat (2) @(negedge clk);
        pwm_in = 1'b1;
        drain();

        fall_seq(16'd1, 16'd1, "R4_R5");

        // R6: reversal during the rising dead phase
        @(negedge clk);
        rise_prop = 16'd0; rise_dead = 16'd6; fall_dead = 16'd2;
        pwm_in = 1'b1;
        c = cyc_tb;
        push(c + 1,  1'b0, 1'b1, "R6");
        push(c + 2,  1'b0, 1'b0, "R6");
        push(c + 4,  1'b0, 1'b0, "R6");
        push(c + 6,  1'b0, 1'b0, "R6");
        push(c + 7,  1'b0, 1'b1, "R6");
        push(c + 10, 1'b0, 1'b1, "R6");
        repeat (3) @(negedge clk);
        pwm_in = 1'b0;
        drain();

        // R9 / R7: high side forced on at T=20, later mode change ignored
        pwm_in = 1'b0; fall_dead = 16'd0;
        fault_sel = 4'd4; fault_at = 32'd20;
        do_reset(c);
        push(c + 20, 1'b0, 1'b1, "R7");
        push(c + 21, 1'b1, 1'b1, "R9");
        push(c + 25, 1'b1, 1'b1, "R7");
        repeat (22) @(negedge clk);
        fault_sel = 4'd7;
        drain();

        // R7: reset clears the latched fault
        fault_sel = 4'd0;
        do_reset(c);
        push(c + 2,  1'b0, 1'b1, "R7");
        push(c + 30, 1'b0, 1'b1, "R7");
        drain();

        // R8: input held at 1 from T=10 goes through the sequencer
        pwm_in = 1'b0; fall_dead = 16'd0; rise_prop = 16'd1; rise_dead = 16'd1;
        fault_sel = 4'd2; fault_at = 32'd10;
        do_reset(c);
        push(c + 13, 1'b0, 1'b1, "R8");
        push(c + 14, 1'b0, 1'b0, "R8");
        push(c + 15, 1'b0, 1'b0, "R8");
        push(c + 16, 1'b1, 1'b0, "R8");
        drain();

        // R9: both sides forced off at T=5 while the high side is on
        pwm_in = 1'b1; rise_dead = 16'd1;
        fault_sel = 4'd7; fault_at = 32'd5;
        do_reset(c);
        push(c + 3, 1'b1, 1'b0, "R1");
        push(c + 5, 1'b1, 1'b0, "R9");
        push(c + 6, 1'b0, 1'b0, "R9");
        push(c + 9, 1'b0, 1'b0, "R9");
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule